// File: doc/BRIEF.md
# Code-Group Synchronization Monitor

This block sits behind the 8b/10b decoder of a serial link receiver. It decides whether the receiver has word alignment, using only three per-character flags from the decoder: a strobe, a comma indication and a code-valid indication. It has no access to the data itself. Comma alignment, decoding and rate matching all happen upstream.

The monitor has four internal conditions: unaligned, acquiring, locked, and locked with outstanding errors. While acquiring, it counts commas until an unbroken run of them is seen. Once locked, it scores invalid code groups. Each long run of good characters forgives one outstanding error. Enough outstanding errors drop the link back to unaligned. A single registered output reports lock, and it is high in both locked conditions.

Top module: `cgs_sync_fsm`

## Requirements
- R1: A synchronous active-high reset clears all counters, puts the block in the unaligned condition and drives `sync_ok` low on the clock edge after reset is sampled.
- R2: On clock edges where `char_stb` is 0, no state or counter changes, so `sync_ok` holds its value.
- R3: Starting from unaligned, `sync_ok` goes high on the edge that takes the 127th comma (`char_comma`=1 with `char_valid`=1). After only 126 commas it stays low.
- R4: During acquisition, a valid non-comma character (`char_valid`=1, `char_comma`=0) neither advances nor clears the comma count.
- R5: During acquisition, an invalid character (`char_valid`=0, whatever `char_comma` is) returns the block to unaligned. A full new run of 127 commas is then needed.
- R6: While unaligned, valid non-comma characters are ignored. Only a comma starts acquisition.
- R7: While locked, one or two invalid characters keep `sync_ok` high.
- R8: The third outstanding invalid character drops `sync_ok` low on the edge that takes it.
- R9: While errors are outstanding, every 255 consecutive valid characters retire one error.
- R10: When the outstanding error count returns to zero, the block is fully locked again. It then takes three new invalid characters to lose lock, and good characters received while fully locked are not banked.
- R11: An invalid character received while errors are outstanding restarts the good-character run from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver character clock |
| rst | input | 1 | Synchronous active-high reset |
| char_stb | input | 1 | A decoded character is present this cycle |
| char_comma | input | 1 | The present character is a comma |
| char_valid | input | 1 | The present character decoded without a code or disparity error |
| sync_ok | output | 1 | Registered link-synchronized status |

## Verification
The assertions assume that the decoder flags are meaningful only while `char_stb` is high. They also assume that a character flagged as a comma but not valid should be treated as invalid. The bench drives the flags from one task at the falling edge, raises the strobe for exactly one cycle per character and leaves idle gaps between characters. This keeps every flag combination inside that contract. The stimulus also includes a comma with the invalid flag set, to exercise the invalid path during acquisition.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

  typedef enum logic [1:0] {
    ST_LOSS     = 2'd0,
    ST_ACQ      = 2'd1,
    ST_LOCK     = 2'd2,
    ST_LOCK_ERR = 2'd3
  } cgs_state_e;

  typedef struct packed {
    logic comma;
    logic good;
    logic bad;
  } cgs_char_t;

  function automatic logic is_locked(input cgs_state_e s);
    return (s == ST_LOCK) || (s == ST_LOCK_ERR);
  endfunction

endpackage

// File: rtl/cgs_char_class.sv
module cgs_char_class
  import cgs_pkg::*;
(
  input  logic      stb,
  input  logic      comma_flag,
  input  logic      valid_flag,
  output cgs_char_t cls
);

  always_comb begin
    cls.bad   = stb && !valid_flag;
    cls.good  = stb && valid_flag;
    cls.comma = stb && valid_flag && comma_flag;
  end

endmodule

// File: rtl/cgs_comma_tracker.sv
module cgs_comma_tracker #(
  parameter int CNT_W  = 7,
  parameter int TARGET = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bump,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);

  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(TARGET - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (bump)    cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == LAST_V);

  assert_comma_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_V);

  assert_comma_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clear && !bump) |=> $stable(cnt));

endmodule

// File: rtl/cgs_err_tracker.sv
module cgs_err_tracker #(
  parameter int GOOD_W   = 8,
  parameter int GOOD_RUN = 255,
  parameter int ERR_W    = 2,
  parameter int ERR_LIM  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              bad,
  input  logic              good,
  output logic [ERR_W-1:0]  err_cnt,
  output logic [GOOD_W-1:0] good_cnt,
  output logic              at_limit,
  output logic              retire_last
);

  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(GOOD_RUN - 1);
  localparam logic [ERR_W-1:0]  ERR_LAST  = ERR_W'(ERR_LIM - 1);
  localparam logic [ERR_W-1:0]  ERR_ONE   = ERR_W'(1);

  logic run_done;
  assign run_done = (good_cnt == GOOD_LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      err_cnt  <= '0;
      good_cnt <= '0;
    end else if (bad) begin
      err_cnt  <= err_cnt + 1'b1;
      good_cnt <= '0;
    end else if (good) begin
      if (run_done) begin
        good_cnt <= '0;
        err_cnt  <= err_cnt - 1'b1;
      end else begin
        good_cnt <= good_cnt + 1'b1;
      end
    end
  end

  assign at_limit    = (err_cnt == ERR_LAST);
  assign retire_last = run_done && (err_cnt == ERR_ONE);

  assert_err_bound_R8: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= ERR_LAST);

  assert_good_bound_R9: assert property (@(posedge clk) disable iff (rst)
    good_cnt <= GOOD_LAST);

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (good && !bad && !clear && run_done) |-> (err_cnt != '0));

  assert_run_restart_R11: assert property (@(posedge clk) disable iff (rst)
    bad |=> (good_cnt == '0));

endmodule

// File: rtl/cgs_sync_fsm.sv
module cgs_sync_fsm
  import cgs_pkg::*;
#(
  parameter int COMMA_W     = 7,
  parameter int SYNC_COMMAS = 127,
  parameter int GOOD_W      = 8,
  parameter int GOOD_RUN    = 255,
  parameter int ERR_W       = 2,
  parameter int ERR_LIM     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic char_stb,
  input  logic char_comma,
  input  logic char_valid,
  output logic sync_ok
);

  cgs_state_e state, nxt;
  cgs_char_t  ch;

  logic               k_clear, k_bump, k_last;
  logic [COMMA_W-1:0] k_cnt;
  logic               e_clear, e_bad, e_good, e_limit, e_retire;
  logic [ERR_W-1:0]   e_cnt;
  logic [GOOD_W-1:0]  g_cnt;

  cgs_char_class u_class (
    .stb        (char_stb),
    .comma_flag (char_comma),
    .valid_flag (char_valid),
    .cls        (ch)
  );

  cgs_comma_tracker #(.CNT_W(COMMA_W), .TARGET(SYNC_COMMAS)) u_comma (
    .clk     (clk),
    .rst     (rst),
    .clear   (k_clear),
    .bump    (k_bump),
    .cnt     (k_cnt),
    .at_last (k_last)
  );

  cgs_err_tracker #(
    .GOOD_W(GOOD_W), .GOOD_RUN(GOOD_RUN), .ERR_W(ERR_W), .ERR_LIM(ERR_LIM)
  ) u_err (
    .clk         (clk),
    .rst         (rst),
    .clear       (e_clear),
    .bad         (e_bad),
    .good        (e_good),
    .err_cnt     (e_cnt),
    .good_cnt    (g_cnt),
    .at_limit    (e_limit),
    .retire_last (e_retire)
  );

  always_comb begin
    nxt     = state;
    k_clear = 1'b0;
    k_bump  = 1'b0;
    e_clear = 1'b0;
    e_bad   = 1'b0;
    e_good  = 1'b0;
    unique case (state)
      ST_LOSS: begin
        e_clear = 1'b1;
        if (ch.comma) begin
          if (k_last) begin
            nxt     = ST_LOCK;
            k_clear = 1'b1;
          end else begin
            nxt    = ST_ACQ;
            k_bump = 1'b1;
          end
        end else if (char_stb) begin
          k_clear = 1'b1;
        end
      end
      ST_ACQ: begin
        e_clear = 1'b1;
        if (ch.bad) begin
          nxt     = ST_LOSS;
          k_clear = 1'b1;
        end else if (ch.comma) begin
          if (k_last) begin
            nxt     = ST_LOCK;
            k_clear = 1'b1;
          end else begin
            k_bump = 1'b1;
          end
        end
      end
      ST_LOCK: begin
        k_clear = 1'b1;
        if (ch.bad) begin
          if (e_limit) begin
            nxt     = ST_LOSS;
            e_clear = 1'b1;
          end else begin
            nxt   = ST_LOCK_ERR;
            e_bad = 1'b1;
          end
        end
      end
      ST_LOCK_ERR: begin
        k_clear = 1'b1;
        if (ch.bad) begin
          if (e_limit) begin
            nxt     = ST_LOSS;
            e_clear = 1'b1;
          end else begin
            e_bad = 1'b1;
          end
        end else if (ch.good) begin
          e_good = 1'b1;
          if (e_retire) nxt = ST_LOCK;
        end
      end
      default: nxt = ST_LOSS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_LOSS;
      sync_ok <= 1'b0;
    end else begin
      state   <= nxt;
      sync_ok <= is_locked(nxt);
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!char_stb) |=> ($stable(state) && $stable(sync_ok)));

  assert_lock_from_acq_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(sync_ok)) |-> ($past(state) != ST_LOCK_ERR));

  assert_loss_on_bad_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(sync_ok)) |-> $past(char_stb && !char_valid));

  assert_err_state_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK_ERR) |-> (e_cnt != '0));

  assert_lock_clean_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK) |-> (e_cnt == '0 && g_cnt == '0));

  assert_status_match_R1: assert property (@(posedge clk) disable iff (rst)
    sync_ok == is_locked(state));

endmodule

// File: tb/cgs_sync_fsm_tb_top.sv
`timescale 1ns/1ps
module cgs_sync_fsm_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic char_stb = 1'b0;
  logic char_comma = 1'b0;
  logic char_valid = 1'b0;
  logic sync_ok;

  int total = 0;
  int bad = 0;
  bit exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  cgs_sync_fsm dut_i (
    .clk        (clk),
    .rst        (rst),
    .char_stb   (char_stb),
    .char_comma (char_comma),
    .char_valid (char_valid),
    .sync_ok    (sync_ok)
  );

  task automatic chk(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sync_ok actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Monitor: one expected item per strobed character, sampled after the edge
  always @(posedge clk) begin
    if (!rst && char_stb) begin
      #1;
      if (exp_q.size() == 0) begin
        chk(1'b1, 1'b0, "scoreboard underrun");
      end else begin
        chk(sync_ok, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  // Driver: one character, strobe high for a single cycle
  task automatic send(input bit comma, input bit valid, input bit exp, input string tag);
    @(negedge clk);
    char_stb   = 1'b1;
    char_comma = comma;
    char_valid = valid;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    char_stb   = 1'b0;
    char_comma = 1'b0;
    char_valid = 1'b0;
  endtask

  task automatic commas(input int n, input bit exp, input string tag);
    for (int i = 0; i < n; i++) send(1'b1, 1'b1, exp, tag);
  endtask

  task automatic data(input int n, input bit exp, input string tag);
    for (int i = 0; i < n; i++) send(1'b0, 1'b1, exp, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(sync_ok, 1'b0, "R1 reset");
    rst = 1'b0;
  endtask

  task automatic idle_check(input int n, input bit exp, input string tag);
    repeat (n) @(negedge clk);
    chk(sync_ok, exp, tag);
  endtask

  task automatic lock_up(input string tag);
    commas(126, 1'b0, tag);
    send(1'b1, 1'b1, 1'b1, tag);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, 1'b1, "scoreboard drained");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1-scope: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sync_ok, 1'b0, "R1 initial reset");
    rst = 1'b0;

    // R3 boundary with R2 idle gap before the last comma
    commas(126, 1'b0, "R3 before threshold");
    idle_check(10, 1'b0, "R2 idle in acquisition");
    send(1'b1, 1'b1, 1'b1, "R3 127th comma");
    idle_check(10, 1'b1, "R2 idle while locked");

    // R1 reset from locked
    do_reset();

    // R4 data interleaved during acquisition
    commas(60, 1'b0, "R4 first part");
    data(5, 1'b0, "R4 data in acquisition");
    commas(66, 1'b0, "R4 second part");
    send(1'b1, 1'b1, 1'b1, "R4 count kept across data");

    // R6 data ignored while unaligned, R5 invalid restarts
    do_reset();
    data(10, 1'b0, "R6 data while unaligned");
    commas(100, 1'b0, "R5 partial run");
    send(1'b1, 1'b0, 1'b0, "R5 invalid comma");
    commas(126, 1'b0, "R5 new run short");
    send(1'b1, 1'b1, 1'b1, "R5 new run complete");

    // R7 / R8
    send(1'b0, 1'b0, 1'b1, "R7 first error");
    send(1'b0, 1'b0, 1'b1, "R7 second error");
    idle_check(5, 1'b1, "R2 idle with errors");
    send(1'b0, 1'b0, 1'b0, "R8 third error");
    data(3, 1'b0, "R6 data after loss");

    // R9 retire one error
    do_reset();
    lock_up("R9 lock");
    send(1'b0, 1'b0, 1'b1, "R9 err1");
    send(1'b0, 1'b0, 1'b1, "R9 err2");
    data(255, 1'b1, "R9 good run");
    send(1'b0, 1'b0, 1'b1, "R9 err after retire");
    send(1'b0, 1'b0, 1'b0, "R9 limit reached");

    // R11 invalid restarts good run
    do_reset();
    lock_up("R11 lock");
    send(1'b0, 1'b0, 1'b1, "R11 err1");
    data(254, 1'b1, "R11 short run 1");
    send(1'b0, 1'b0, 1'b1, "R11 err2");
    data(254, 1'b1, "R11 short run 2");
    send(1'b0, 1'b0, 1'b0, "R11 err3 no retire");

    // R10 full recovery then fresh count, no banking of good characters
    do_reset();
    lock_up("R10 lock");
    send(1'b0, 1'b0, 1'b1, "R10 err1");
    data(255, 1'b1, "R10 recover");
    data(300, 1'b1, "R10 good while clean");
    send(1'b0, 1'b0, 1'b1, "R10 new err1");
    send(1'b0, 1'b0, 1'b1, "R10 new err2");
    data(254, 1'b1, "R10 run not banked");
    send(1'b0, 1'b0, 1'b0, "R10 new err3");

    finish_run();
  end

endmodule